// File: doc/BRIEF.md
# Sixteen-bit ALU with shifts

This block is the arithmetic and logic unit of a small sixteen-register processor. It is purely combinational: a 3-bit operation select picks one of eight functions of two 16-bit operands. Out come a 16-bit result, a zero flag and a signed less-than flag. The branch logic uses the less-than flag for compare-and-branch. The zero flag drives a jump taken on zero.

Operand B reaches the block either as a register value or as an immediate that the caller has already extended. The addition path serves register adds, immediate adds, the accumulate-in-place forms and memory address generation. The shift functions take their distance from the low four bits of B. The load-upper function places the low byte of B in the high byte of the result. The block holds no state and has no clock.

Top module: `alu16_core`

## Requirements
- R1: Select 000 drives the result with A plus B, modulo 2^16.
- R2: Select 001 drives the result with bits 7:0 of B in bits 15:8 and 0x00 in bits 7:0. Bits 15:8 of B have no effect; B = 0x00FF gives 0xFF00.
- R3: Select 010 drives the result with A shifted left, with zeros entering at bit 0.
- R4: Select 011 drives the result with A shifted right, with copies of A[15] entering at bit 15.
- R5: Select 111 drives the result with A shifted right, with zeros entering at bit 15.
- R6: For the three shifts, the distance is B[3:0] and bits 15:4 of B have no effect. A distance of 0 gives A unchanged.
- R7: Select 100 drives the bitwise XOR of A and B. Select 101 drives the bitwise OR of A and B.
- R8: Select 110 drives the result with A minus B, modulo 2^16.
- R9: The less-than output is 1 exactly when the select is 110 and A is less than B as signed two's-complement values. It is 0 for every other select.
- R10: The zero output is 1 exactly when the 16-bit result is 0x0000, for every select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opsel_i | input | 3 | Operation select (encodings in R1 to R9) |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B: register value or extended immediate |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | Result equals 0x0000 |
| less_o | output | 1 | Signed A < B, valid for select 110 only |

## Verification
The block has no register anywhere between its inputs and its outputs. Result, zero and less-than are therefore all due in the same cycle the operands and select are applied, zero cycles later. The bench changes inputs just after a rising edge and samples all three outputs at the following falling edge, so each result has half a period to settle. The bench never reads an output in the cycle its inputs change. The expected values come from a hand-computed vector table plus a sweep of every shift distance, with the expected shift computed in the bench.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_LUI = 3'b001,
        OP_SHL = 3'b010,
        OP_SRA = 3'b011,
        OP_XOR = 3'b100,
        OP_OR  = 3'b101,
        OP_CMP = 3'b110,
        OP_SRL = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         slt_o
);
    logic [W-1:0] b_eff;
    logic         ovf;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        ovf   = (a_i[W-1] != b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
        slt_o = sub_i & (sum_o[W-1] ^ ovf);

        // R9: a strict less-than can never come with equal operands
        assert_lt_nonzero_R9: assert (!slt_o || (sum_o != '0))
            else $error("less-than with zero difference");
        // R1: adding zero returns A
        assert_add_identity_R1: assert (sub_i || (b_i != '0) || (sum_o == a_i))
            else $error("A + 0 differs from A");
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  res_o
);
    logic [W-1:0] v;

    always_comb begin
        v = a_i;
        for (int k = 0; k < SW; k++) begin
            if (amt_i[k]) begin
                if (left_i)
                    v = v << (1 << k);
                else if (arith_i)
                    v = W'($signed(v) >>> (1 << k));
                else
                    v = v >> (1 << k);
            end
        end
        res_o = v;

        // R6: zero distance passes A through
        assert_shift_zero_R6: assert ((amt_i != '0) || (res_o == a_i))
            else $error("zero shift altered A");
        // R4: arithmetic right keeps the sign bit
        assert_sra_sign_R4: assert (left_i || !arith_i || (res_o[W-1] == a_i[W-1]))
            else $error("sign bit lost in arithmetic shift");
        // R5: logical right with nonzero distance clears the top bit
        assert_srl_fill_R5: assert (left_i || arith_i || (amt_i == '0) || !res_o[W-1])
            else $error("logical right shift filled with one");
    end
endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] upper_o
);
    localparam int HALF = W / 2;

    always_comb begin
        xor_o   = a_i ^ b_i;
        or_o    = a_i | b_i;
        upper_o = {b_i[HALF-1:0], {(W-HALF){1'b0}}};
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
    parameter int WIDTH = 16
) (
    input  logic [2:0]       opsel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             less_o
);
    import alu16_pkg::*;

    localparam int SHW = $clog2(WIDTH);

    alu_op_e          op;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] shift_res;
    logic [WIDTH-1:0] xor_res;
    logic [WIDTH-1:0] or_res;
    logic [WIDTH-1:0] upper_res;
    logic             slt;
    logic             is_cmp;
    logic             shl;
    logic             sra;

    always_comb begin
        op     = alu_op_e'(opsel_i);
        is_cmp = (op == OP_CMP);
        shl    = (op == OP_SHL);
        sra    = (op == OP_SRA);
    end

    alu16_addsub #(.W(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (is_cmp),
        .sum_o (arith_res),
        .slt_o (slt)
    );

    alu16_shift #(.W(WIDTH), .SW(SHW)) u_shift (
        .a_i     (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (shl),
        .arith_i (sra),
        .res_o   (shift_res)
    );

    alu16_bitwise #(.W(WIDTH)) u_bitwise (
        .a_i     (a_i),
        .b_i     (b_i),
        .xor_o   (xor_res),
        .or_o    (or_res),
        .upper_o (upper_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_CMP:  result_o = arith_res;
            OP_LUI:  result_o = upper_res;
            OP_SHL,
            OP_SRA,
            OP_SRL:  result_o = shift_res;
            OP_XOR:  result_o = xor_res;
            OP_OR:   result_o = or_res;
            default: result_o = '0;
        endcase
        zero_o = (result_o == '0);
        less_o = slt;

        // R9: less-than only ever reported in compare mode
        assert_less_cmp_only_R9: assert (!less_o || is_cmp)
            else $error("less-than outside compare");
    end
endmodule

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  opsel;
    logic [15:0] a, b;
    logic [15:0] result;
    logic        zero, less;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu16_core u0 (
        .opsel_i  (opsel),
        .a_i      (a),
        .b_i      (b),
        .result_o (result),
        .zero_o   (zero),
        .less_o   (less)
    );

    // {op, a, b, result, zero, less}
    localparam logic [52:0] VEC [20] = '{
        {3'b000, 16'h1234, 16'h0001, 16'h1235, 1'b0, 1'b0},
        {3'b000, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0},
        {3'b001, 16'h5555, 16'h00FF, 16'hFF00, 1'b0, 1'b0},
        {3'b001, 16'h0000, 16'h1201, 16'h0100, 1'b0, 1'b0},
        {3'b010, 16'h0001, 16'h0004, 16'h0010, 1'b0, 1'b0},
        {3'b010, 16'h8001, 16'h0011, 16'h0002, 1'b0, 1'b0},
        {3'b010, 16'h1234, 16'h0000, 16'h1234, 1'b0, 1'b0},
        {3'b011, 16'h8000, 16'h0003, 16'hF000, 1'b0, 1'b0},
        {3'b011, 16'h4000, 16'h0002, 16'h1000, 1'b0, 1'b0},
        {3'b111, 16'h8000, 16'h0003, 16'h1000, 1'b0, 1'b0},
        {3'b111, 16'hFFFF, 16'h000F, 16'h0001, 1'b0, 1'b0},
        {3'b100, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0, 1'b0},
        {3'b100, 16'hAAAA, 16'hAAAA, 16'h0000, 1'b1, 1'b0},
        {3'b101, 16'h0F00, 16'h00F0, 16'h0FF0, 1'b0, 1'b0},
        {3'b110, 16'hFFFF, 16'h0001, 16'hFFFE, 1'b0, 1'b1},
        {3'b110, 16'h0001, 16'hFFFF, 16'h0002, 1'b0, 1'b0},
        {3'b110, 16'h0005, 16'h0005, 16'h0000, 1'b1, 1'b0},
        {3'b110, 16'h8000, 16'h7FFF, 16'h0001, 1'b0, 1'b1},
        {3'b110, 16'h7FFF, 16'h8000, 16'hFFFF, 1'b0, 1'b0},
        {3'b011, 16'h8001, 16'h0010, 16'h8001, 1'b0, 1'b0}
    };

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3/R6";
            3'b011: return "R4/R6";
            3'b111: return "R5/R6";
            3'b100, 3'b101: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [15:0] va, input logic [15:0] vb);
        @(posedge clk);
        #1;
        opsel = op; a = va; b = vb;
        @(negedge clk);
    endtask

    initial begin
        opsel = 3'b000; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero operands, add
        check("R10", "reset result", result, 16'h0000);
        check("R10", "reset zero",   {15'b0, zero}, 16'h0001);
        check("R9",  "reset less",   {15'b0, less}, 16'h0000);

        for (int i = 0; i < 20; i++) begin
            apply(VEC[i][52:50], VEC[i][49:34], VEC[i][33:18]);
            check(req_of(VEC[i][52:50]), "result", result, VEC[i][17:2]);
            check("R10", "zero", {15'b0, zero}, {15'b0, VEC[i][1]});
            check("R9",  "less", {15'b0, less}, {15'b0, VEC[i][0]});
        end

        // R6: every distance, upper bits of B set to show they are ignored
        for (int k = 0; k < 16; k++) begin
            apply(3'b010, 16'hB6D3, 16'hFFF0 | 16'(k));
            check("R6", "shl sweep", result, 16'hB6D3 << k);
            apply(3'b111, 16'hB6D3, 16'hABC0 | 16'(k));
            check("R6", "srl sweep", result, 16'hB6D3 >> k);
            apply(3'b011, 16'hB6D3, 16'h1230 | 16'(k));
            check("R6", "sra sweep", result, 16'($signed(16'hB6D3) >>> k));
        end

        // R9: signed A < B but select is not compare
        apply(3'b100, 16'h8000, 16'h0001);
        check("R9", "less on xor", {15'b0, less}, 16'h0000);
        apply(3'b101, 16'hFFFE, 16'h0003);
        check("R9", "less on or", {15'b0, less}, 16'h0000);
        // R10: zero flag on a shift that clears everything
        apply(3'b010, 16'h8000, 16'h0001);
        check("R10", "zero on shl", {15'b0, zero}, 16'h0001);
        // R2: upper byte of B ignored, zero flag when low byte is 0
        apply(3'b001, 16'hFFFF, 16'hFF00);
        check("R2", "lui upper ignored", result, 16'h0000);
        check("R10", "zero on lui", {15'b0, zero}, 16'h0001);
        // R8: compare wraps
        apply(3'b110, 16'h0000, 16'h0001);
        check("R8", "cmp wrap", result, 16'hFFFF);
        check("R9", "cmp 0<1", {15'b0, less}, 16'h0001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule